// File: doc/BRIEF.md
# Ring L2 Write-Ownership Tracker

This block sits beside a shared L2 cache on a message ring that serves several L1 caches. For each line it tracks it holds at most one write owner (a core ID) and a single flag saying that a flush has already been sent to that owner. Read and write-privilege requests come in tagged with the requesting core. A request that does not collide with another core's ownership is answered at once, and a write request claims the line for the requester. A request that collides is not answered. It is handed back to the ring as a pass so the requester retries it when it next comes round. The first such collision also sends a flush request to the current owner.

The owner answers a flush either with write-back data, which the block forwards to the L2 data array, or with a bare acknowledgement when its copy is clean. Either answer releases the line. Tracking is direct-mapped on the low line-address bits and checks a stored tag. A line that is not tracked counts as unowned. When a write request lands on a slot that holds a different line, the block flushes the line in that slot first. Each input message produces registered outputs one cycle later. A reply slot carries a response or a pass to the requester. A flush slot carries the flush request to the owner. A write port feeds the L2 array.

Top module: `ring_own_tracker`

## Requirements
- R1: After reset every slot is unowned with no flush pending, and no output is valid until a message is presented.
- R2: A read request (kind 0) to a line that no other core owns gets a RESPONSE (out_kind 0) to the requester and changes no ownership.
- R3: A write-privilege request (kind 1) to an unowned slot records the requester as owner and gets a RESPONSE to it.
- R4: A read or write request from the core that already owns the line gets a RESPONSE and produces no flush request.
- R5: A request to a line owned by another core, with no flush pending, produces a flush request to the owner carrying the line address, together with a PASS (out_kind 2) of the request to the requester in the same cycle.
- R6: While a flush is pending on a line, further conflicting requests produce a PASS only and no duplicate flush request.
- R7: Write-back data (kind 3) for a tracked line is written to L2 at the line address, and the line becomes unowned.
- R8: A flush acknowledgement (kind 2) for a tracked line releases it without any L2 write. Acknowledgements and write-backs produce no reply message.
- R9: An acknowledgement or write-back whose address is not the tracked line in its slot is ignored: no L2 write, and ownership and pending state stay as they were.
- R10: A write request to a slot that holds a different line flushes that resident line (its own address, to its owner) and is passed. A read to such an alias is answered.
- R11: Outputs appear exactly one clock after the input message. A cycle with no input message produces no valid output the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A ring message is presented this cycle |
| in_kind | input | 2 | 0 read, 1 write-privilege, 2 flush acknowledge, 3 write-back data |
| in_core | input | CORE_W | Sending core ID |
| in_addr | input | ADDR_W | Line address |
| in_data | input | DATA_W | Write-back payload |
| out_valid | output | 1 | Reply message valid |
| out_kind | output | 2 | 0 RESPONSE, 2 PASS |
| out_core | output | CORE_W | Destination core of the reply |
| out_addr | output | ADDR_W | Line address of the reply |
| fl_valid | output | 1 | Flush request valid |
| fl_kind | output | 2 | Always 1 (FLUSH_REQ) when valid |
| fl_core | output | CORE_W | Owner core that must flush |
| fl_addr | output | ADDR_W | Line to flush |
| l2_we | output | 1 | L2 data array write enable |
| l2_waddr | output | ADDR_W | L2 write line address |
| l2_wdata | output | DATA_W | L2 write data |

## Verification
The embedded properties hold on every cycle. They check that a flush is always paired with a pass, that a pending flag is only ever set on an owned slot that has no flush outstanding, that a slot is claimed only while it is free, that releases produce no reply, and that nothing is output without an input the cycle before. Only the bench scenarios can show the end-to-end ordering: which core receives which message, that a release really frees the line for the next writer, that a stray acknowledgement leaves the pending flush in place, and that aliasing picks the resident line's address. The bench sweeps every owner and requester pair for both request kinds and both release kinds.

// File: rtl/own_trk_pkg.sv
package own_trk_pkg;
  typedef enum logic [1:0] {
    MSG_RD  = 2'd0,
    MSG_WR  = 2'd1,
    MSG_ACK = 2'd2,
    MSG_WB  = 2'd3
  } in_kind_e;

  typedef enum logic [1:0] {
    RPY_RESP  = 2'd0,
    RPY_FLUSH = 2'd1,
    RPY_PASS  = 2'd2
  } out_kind_e;
endpackage

// File: rtl/own_trk_table.sv
module own_trk_table #(
  parameter int CORE_W = 2,
  parameter int TAG_W  = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  output logic              rd_vld,
  output logic              rd_pend,
  output logic [CORE_W-1:0] rd_owner,
  output logic [TAG_W-1:0]  rd_tag,
  input  logic              set_own,
  input  logic              set_pend,
  input  logic              clr,
  input  logic [CORE_W-1:0] new_owner,
  input  logic [TAG_W-1:0]  new_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  vld_q;
  logic [LINES-1:0]  pnd_q;
  logic [CORE_W-1:0] own_mem [LINES];
  logic [TAG_W-1:0]  tag_mem [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      pnd_q <= '0;
    end else begin
      if (set_own)  vld_q[idx] <= 1'b1;
      if (set_pend) pnd_q[idx] <= 1'b1;
      if (clr) begin
        vld_q[idx] <= 1'b0;
        pnd_q[idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (set_own) begin
      own_mem[idx] <= new_owner;
      tag_mem[idx] <= new_tag;
    end
  end

  assign rd_vld   = vld_q[idx];
  assign rd_pend  = pnd_q[idx];
  assign rd_owner = own_mem[idx];
  assign rd_tag   = tag_mem[idx];

  // R6
  pend_on_owned_chk: assert property (@(posedge clk) disable iff (rst)
    set_pend |-> (vld_q[idx] && !pnd_q[idx]));
  // R3
  claim_free_slot_chk: assert property (@(posedge clk) disable iff (rst)
    set_own |-> !vld_q[idx]);
endmodule

// File: rtl/own_trk_decide.sv
module own_trk_decide
  import own_trk_pkg::*;
#(
  parameter int CORE_W = 2,
  parameter int TAG_W  = 8,
  parameter int IDX_W  = 4
) (
  input  logic              req_v,
  input  logic [1:0]        req_kind,
  input  logic [CORE_W-1:0] req_core,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic              e_vld,
  input  logic              e_pend,
  input  logic [CORE_W-1:0] e_owner,
  input  logic [TAG_W-1:0]  e_tag,
  output logic              rpy_v,
  output logic [1:0]        rpy_kind,
  output logic              fl_v,
  output logic [TAG_W+IDX_W-1:0] fl_line,
  output logic              set_own,
  output logic              set_pend,
  output logic              clr,
  output logic              wb_we
);
  logic hit, mine, conflict;

  always_comb begin
    hit      = e_vld && (e_tag == req_tag);
    mine     = hit && (e_owner == req_core);
    conflict = 1'b0;
    rpy_v    = 1'b0;
    rpy_kind = RPY_RESP;
    set_own  = 1'b0;
    clr      = 1'b0;
    wb_we    = 1'b0;
    if (req_v) begin
      unique case (in_kind_e'(req_kind))
        MSG_RD: begin
          rpy_v    = 1'b1;
          conflict = hit && !mine;
        end
        MSG_WR: begin
          rpy_v    = 1'b1;
          conflict = e_vld && !mine;
          set_own  = !e_vld;
        end
        MSG_ACK: clr = hit;
        MSG_WB: begin
          clr   = hit;
          wb_we = hit;
        end
        default: ;
      endcase
    end
    if (conflict) rpy_kind = RPY_PASS;
    fl_v     = conflict && !e_pend;
    set_pend = fl_v;
    fl_line  = {e_tag, req_idx};
  end
endmodule

// File: rtl/ring_own_tracker.sv
module ring_own_tracker
  import own_trk_pkg::*;
#(
  parameter int CORE_W = 2,
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        in_kind,
  input  logic [CORE_W-1:0] in_core,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [CORE_W-1:0] out_core,
  output logic [ADDR_W-1:0] out_addr,
  output logic              fl_valid,
  output logic [1:0]        fl_kind,
  output logic [CORE_W-1:0] fl_core,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              l2_we,
  output logic [ADDR_W-1:0] l2_waddr,
  output logic [DATA_W-1:0] l2_wdata
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              e_vld, e_pend;
  logic [CORE_W-1:0] e_owner;
  logic [TAG_W-1:0]  e_tag;
  logic              rpy_v, fl_v, set_own, set_pend, clr, wb_we;
  logic [1:0]        rpy_kind;
  logic [ADDR_W-1:0] fl_line;

  assign idx = in_addr[IDX_W-1:0];
  assign tag = in_addr[ADDR_W-1:IDX_W];

  own_trk_table #(.CORE_W(CORE_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) table_i (
    .clk(clk), .rst(rst), .idx(idx),
    .rd_vld(e_vld), .rd_pend(e_pend), .rd_owner(e_owner), .rd_tag(e_tag),
    .set_own(set_own), .set_pend(set_pend), .clr(clr),
    .new_owner(in_core), .new_tag(tag)
  );

  own_trk_decide #(.CORE_W(CORE_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) decide_i (
    .req_v(in_valid), .req_kind(in_kind), .req_core(in_core),
    .req_tag(tag), .req_idx(idx),
    .e_vld(e_vld), .e_pend(e_pend), .e_owner(e_owner), .e_tag(e_tag),
    .rpy_v(rpy_v), .rpy_kind(rpy_kind), .fl_v(fl_v), .fl_line(fl_line),
    .set_own(set_own), .set_pend(set_pend), .clr(clr), .wb_we(wb_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      fl_valid  <= 1'b0;
      l2_we     <= 1'b0;
    end else begin
      out_valid <= rpy_v;
      fl_valid  <= fl_v;
      l2_we     <= wb_we;
    end
    out_kind <= rpy_kind;
    out_core <= in_core;
    out_addr <= in_addr;
    fl_core  <= e_owner;
    fl_addr  <= fl_line;
    l2_waddr <= in_addr;
    l2_wdata <= in_data;
  end

  assign fl_kind = RPY_FLUSH;

  // R5
  flush_with_pass_chk: assert property (@(posedge clk) disable iff (rst)
    fl_valid |-> (out_valid && out_kind == RPY_PASS));
  // R8
  release_silent_chk: assert property (@(posedge clk) disable iff (rst)
    l2_we |-> !out_valid);
  // R11
  no_spurious_out_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> (!out_valid && !fl_valid && !l2_we));
endmodule

// File: tb/ring_own_tracker_tb.sv
module ring_own_tracker_tb_top;
  localparam int CW = 2, IW = 2, AW = 4, DW = 8;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, ACK = 2'd2, WB = 2'd3;
  localparam logic [1:0] RESP = 2'd0, PASS = 2'd2;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_kind = '0;
  logic [CW-1:0] in_core = '0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, fl_valid, l2_we;
  logic [1:0] out_kind, fl_kind;
  logic [CW-1:0] out_core, fl_core;
  logic [AW-1:0] out_addr, fl_addr, l2_waddr;
  logic [DW-1:0] l2_wdata;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ring_own_tracker #(.CORE_W(CW), .IDX_W(IW), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
    .in_core(in_core), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_kind(out_kind), .out_core(out_core),
    .out_addr(out_addr), .fl_valid(fl_valid), .fl_kind(fl_kind),
    .fl_core(fl_core), .fl_addr(fl_addr), .l2_we(l2_we),
    .l2_waddr(l2_waddr), .l2_wdata(l2_wdata)
  );

  task automatic send(input logic [1:0] k, input int c, input int a, input int d);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_core = CW'(c); in_addr = AW'(a); in_data = DW'(d);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  // expected: reply valid/kind/core/addr, flush valid/core/addr, l2 write valid/addr/data
  task automatic chk(input string rq, input bit ov, input logic [1:0] ok, input int oc,
                     input int oa, input bit fv, input int fc, input int fa,
                     input bit wv, input int wa, input int wd);
    logic [63:0] act, exp;
    act = {out_valid, out_valid ? {out_kind, 4'(out_core), 4'(out_addr)} : 10'd0,
           fl_valid, fl_valid ? {fl_kind, 4'(fl_core), 4'(fl_addr)} : 10'd0,
           l2_we, l2_we ? {4'(l2_waddr), 8'(l2_wdata)} : 12'd0};
    exp = {ov, ov ? {ok, 4'(oc), 4'(oa)} : 10'd0,
           fv, fv ? {2'd1, 4'(fc), 4'(fa)} : 10'd0,
           wv, wv ? {4'(wa), 8'(wd)} : 12'd0};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: idle outputs after reset
    idle();
    chk("R1 idle after reset", 0, RESP, 0, 0, 0, 0, 0, 0, 0, 0);
    // R11: a single idle cycle after traffic gives nothing
    send(RD, 1, 2, 0);
    chk("R2 read unowned", 1, RESP, 1, 2, 0, 0, 0, 0, 0, 0);
    idle();
    chk("R11 no input no output", 0, RESP, 0, 0, 0, 0, 0, 0, 0, 0);
    // R2: read did not claim the line
    send(WR, 3, 2, 0);
    chk("R2 write after read free", 1, RESP, 3, 2, 0, 0, 0, 0, 0, 0);
    send(ACK, 3, 2, 0);
    chk("R8 ack silent", 0, RESP, 0, 0, 0, 0, 0, 0, 0, 0);

    // sweep every owner/requester pair, both request kinds
    for (int o = 0; o < 4; o++)
      for (int r = 0; r < 4; r++)
        for (int k = 0; k < 2; k++) begin
          int a = (o * 4 + r + k * 7) % 16;
          int d = o * 32 + r * 8 + k + 1;
          bit use_wb = ((o + r + k) % 2) == 0;
          send(WR, o, a, 0);
          chk("R3 claim", 1, RESP, o, a, 0, 0, 0, 0, 0, 0);
          send(2'(k), r, a, 0);
          if (r == o) chk("R4 owner served", 1, RESP, r, a, 0, 0, 0, 0, 0, 0);
          else begin
            chk("R5 flush and pass", 1, PASS, r, a, 1, o, a, 0, 0, 0);
            send(2'(k), r, a, 0);
            chk("R6 pass only", 1, PASS, r, a, 0, 0, 0, 0, 0, 0);
          end
          if (use_wb) begin
            send(WB, o, a, d);
            chk("R7 writeback", 0, RESP, 0, 0, 0, 0, 0, 1, a, d);
          end else begin
            send(ACK, o, a, 0);
            chk("R8 ack release", 0, RESP, 0, 0, 0, 0, 0, 0, 0, 0);
          end
          send(WR, r, a, 0);
          chk("R7 R8 line freed", 1, RESP, r, a, 0, 0, 0, 0, 0, 0);
          send(ACK, r, a, 0);
        end

    // R10: aliasing on slot 1 (addr 5 tag 1, addr 9 tag 2, addr 13 tag 3)
    send(WR, 1, 5, 0);
    chk("R3 claim alias base", 1, RESP, 1, 5, 0, 0, 0, 0, 0, 0);
    send(WR, 2, 9, 0);
    chk("R10 alias write flushes resident", 1, PASS, 2, 9, 1, 1, 5, 0, 0, 0);
    send(RD, 3, 13, 0);
    chk("R10 alias read served", 1, RESP, 3, 13, 0, 0, 0, 0, 0, 0);
    // R9: stray release for untracked line in that slot
    send(WB, 2, 9, 8'h5A);
    chk("R9 stray writeback ignored", 0, RESP, 0, 0, 0, 0, 0, 0, 0, 0);
    send(ACK, 0, 13, 0);
    chk("R9 stray ack ignored", 0, RESP, 0, 0, 0, 0, 0, 0, 0, 0);
    send(WR, 2, 9, 0);
    chk("R9 pending kept", 1, PASS, 2, 9, 0, 0, 0, 0, 0, 0);
    send(RD, 1, 5, 0);
    chk("R9 owner kept", 1, RESP, 1, 5, 0, 0, 0, 0, 0, 0);
    send(WB, 1, 5, 8'hC3);
    chk("R7 resident writeback", 0, RESP, 0, 0, 0, 0, 0, 1, 5, 8'hC3);
    send(WR, 2, 9, 0);
    chk("R10 alias claims after release", 1, RESP, 2, 9, 0, 0, 0, 0, 0, 0);

    // R1: reset drops ownership
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    idle();
    chk("R1 reset idle", 0, RESP, 0, 0, 0, 0, 0, 0, 0, 0);
    send(WR, 0, 9, 0);
    chk("R1 reset cleared owner", 1, RESP, 0, 9, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule